// File: doc/BRIEF.md
# Loss-of-Signal Supervisor with Output Muting

This block watches the recovered serial data of a four-channel receiver and decides, for each channel on its own, whether the line has lost its signal. Two sources can raise that decision. The first is a digital activity detector. It samples the recovered bit in the reference-clock domain through a two-stage synchronizer and times the gaps between transitions. It declares loss when a gap grows longer than a short threshold. It releases only after a much longer window has passed in which no gap exceeded that threshold. The second source is an external signal-detect pin from the optical module. Its active level is chosen per channel, and it raises loss in the same cycle it goes inactive, with no filtering.

Each channel reports a status bit, which is the OR of the external condition and the digital condition. A global disable input turns off the digital condition, both in the status bit and in muting. Whenever the status bit is high, the channel's data output is forced to logic zero. Otherwise the output carries the synchronized bit. A rate-select input picks one of two sets of threshold and window counts, so the timing follows whichever reference frequency is in use. The serial path carries one bit per reference cycle. It is not a valid/ready stream and has no back-pressure, because the recovered data cannot be held. All control and status pins are plain level signals.

Top module: `los_supervisor`

## Requirements
- R1: The four channels are independent. A channel's status and output depend only on its own data, detect and polarity inputs and on the shared disable and rate inputs.
- R2: When a channel is not muted, `data_out[c]` equals the value `rx_data[c]` had before the second rising clock edge preceding the sample. This gives two cycles of synchronizer latency.
- R3: A transition is a change between two consecutive synchronized samples. If more than T consecutive cycles pass without a transition, the digital condition is declared. T is the threshold selected by R6. After a single change of `rx_data[c]` with no further change, the status bit is still low after T+3 rising edges and is high after T+4.
- R4: A declared digital condition clears only after W consecutive cycles in which no gap exceeded T. W is the window selected by R6. Data that changes every P cycles clears the condition if P <= T+1 and keeps it declared if P >= T+2.
- R5: Any gap longer than T while the condition is declared restarts the clearing window from zero.
- R6: `rate_sel`=1 selects T=DECL_HI and W=WIN_HI. `rate_sel`=0 selects T=DECL_LO and W=WIN_LO. The defaults are 195/9953 and 49/2489 cycles.
- R7: The external condition is `sig_det[c] != det_pol[c]`, where `det_pol`=1 means detect is active-high and 0 means active-low. It reaches `los_stat[c]` combinationally, in the same cycle.
- R8: `los_stat[c]` is the external condition OR (digital condition AND `dlos_off`=0).
- R9: While `los_stat[c]` is high, `data_out[c]` is 0.
- R10: While `dlos_off`=1, the digital condition neither sets the status bit nor mutes the output. Clearing `dlos_off` makes a declared digital condition visible at once.
- R11: After reset, the digital condition of every channel is declared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | NCH | Recovered serial data, one bit per channel |
| sig_det | input | NCH | External signal-detect from the optical module |
| det_pol | input | NCH | Active level of `sig_det` (1 = high) |
| dlos_off | input | 1 | Disables digital loss detection and its muting |
| rate_sel | input | 1 | Reference rate: 1 = fast counts, 0 = slow counts |
| data_out | output | NCH | Synchronized data, forced to 0 when muted |
| los_stat | output | NCH | Per-channel loss-of-signal status |

## Verification
The bench sweeps transition spacings across the exact boundary P = T+1 / T+2 for both rate settings, with a different spacing on each channel. A detector that compared the gap with the wrong bound, or that used the other rate's counts, flips the result on the boundary channel. Declare timing is checked on the exact edge, and clearing is checked just before and just after the window. A gap inserted near the end of a clearing window catches a design that pauses the window instead of restarting it: such a design would clear too early. All 256 combinations of detect and polarity are checked with digital detection disabled, which catches an inverted polarity sense, a registered external path, or digital loss leaking through the disable.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/los_sync.sv
module los_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dsync,
  output logic toggled
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign dsync   = sync_q;
  assign toggled = sync_q ^ prev_q;
endmodule

// File: rtl/los_gap_timer.sv
module los_gap_timer #(
  parameter int CW   = 14,
  parameter int TMAX = 195,
  parameter int WMAX = 9953
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          toggled,
  input  logic [CW-1:0] thr_i,
  input  logic [CW-1:0] win_i,
  output logic          dig_los
);
  logic [CW-1:0] gap_q, win_q;
  logic          los_q;
  logic          overrun;

  assign overrun = !toggled && (gap_q >= thr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= CW'(TMAX);
    end else if (toggled) begin
      gap_q <= '0;
    end else if (gap_q < thr_i) begin
      gap_q <= gap_q + 1'b1;
    end else begin
      gap_q <= thr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q <= 1'b1;
      win_q <= '0;
    end else if (!los_q) begin
      win_q <= '0;
      if (overrun) los_q <= 1'b1;
    end else if (overrun) begin
      win_q <= '0;
    end else if (win_q + 1'b1 >= win_i) begin
      win_q <= '0;
      los_q <= 1'b0;
    end else begin
      win_q <= win_q + 1'b1;
    end
  end

  assign dig_los = los_q;

  p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= CW'(TMAX));
  p_win_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= CW'(WMAX));
  p_rise_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> !$past(toggled));
  p_fall_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_q) |-> ($past(win_q) + 1'b1 >= $past(win_i)));
endmodule

// File: rtl/los_channel.sv
module los_channel #(
  parameter int CW   = 14,
  parameter int TMAX = 195,
  parameter int WMAX = 9953
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_bit,
  input  logic          det_bit,
  input  logic          pol_bit,
  input  logic          dig_off,
  input  logic [CW-1:0] thr_i,
  input  logic [CW-1:0] win_i,
  output logic          out_bit,
  output logic          stat_bit
);
  logic dsync, toggled, dig_los, ext_los;

  los_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (rx_bit),
    .dsync   (dsync),
    .toggled (toggled)
  );

  los_gap_timer #(.CW(CW), .TMAX(TMAX), .WMAX(WMAX)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .toggled (toggled),
    .thr_i   (thr_i),
    .win_i   (win_i),
    .dig_los (dig_los)
  );

  assign ext_los  = det_bit ^ pol_bit;
  assign stat_bit = ext_los | (dig_los & ~dig_off);
  assign out_bit  = dsync & ~stat_bit;

  p_ext_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_los |-> stat_bit);
  p_off_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_off && !ext_los) |-> !stat_bit);
  p_mute_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_bit |-> !out_bit);
endmodule

// File: rtl/los_supervisor.sv
module los_supervisor #(
  parameter int NCH     = 4,
  parameter int DECL_HI = 195,
  parameter int DECL_LO = 49,
  parameter int WIN_HI  = 9953,
  parameter int WIN_LO  = 2489
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] rx_data,
  input  logic [NCH-1:0] sig_det,
  input  logic [NCH-1:0] det_pol,
  input  logic           dlos_off,
  input  logic           rate_sel,
  output logic [NCH-1:0] data_out,
  output logic [NCH-1:0] los_stat
);
  import los_pkg::*;

  localparam int TMAX = max2(DECL_HI, DECL_LO);
  localparam int WMAX = max2(WIN_HI, WIN_LO);
  localparam int CW   = $clog2(max2(TMAX, WMAX) + 2);

  rate_e         rate;
  logic [CW-1:0] thr_sel, win_sel;

  assign rate    = rate_e'(rate_sel);
  assign thr_sel = (rate == RATE_FAST) ? CW'(DECL_HI) : CW'(DECL_LO);
  assign win_sel = (rate == RATE_FAST) ? CW'(WIN_HI)  : CW'(WIN_LO);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    los_channel #(.CW(CW), .TMAX(TMAX), .WMAX(WMAX)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_bit   (rx_data[c]),
      .det_bit  (sig_det[c]),
      .pol_bit  (det_pol[c]),
      .dig_off  (dlos_off),
      .thr_i    (thr_sel),
      .win_i    (win_sel),
      .out_bit  (data_out[c]),
      .stat_bit (los_stat[c])
    );
  end

  p_no_leak_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_out & los_stat) == '0);
endmodule

// File: tb/test_los_supervisor.sv
module test_los_supervisor;
  localparam int NCH = 4, DH = 12, DL = 5, WH = 40, WL = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH-1:0] rx = '0, sd = '1, pol = '1;
  logic off = 1'b0, rate = 1'b1;
  logic [NCH-1:0] dout, los;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  los_supervisor #(.NCH(NCH), .DECL_HI(DH), .DECL_LO(DL), .WIN_HI(WH), .WIN_LO(WL))
  i_los_supervisor (
    .clk(clk), .rst_n(rst_n), .rx_data(rx), .sig_det(sd), .det_pol(pol),
    .dlos_off(off), .rate_sel(rate), .data_out(dout), .los_stat(los)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx = '0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic toggle_run(input int base, input int step, input int ncyc);
    for (int n = 0; n < ncyc; n++) begin
      for (int c = 0; c < NCH; c++)
        if (n % (base + step * c) == 0) rx[c] = ~rx[c];
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(1);
    do_reset();
    // R11: declared after reset, outputs muted
    chk("R11 reset status", 32'(los), 32'hF);
    chk("R11 reset output", 32'(dout), 32'h0);

    // R3 R4 R6 R1: spacing sweep, staggered per channel, both rates
    for (int r = 0; r < 2; r++) begin
      for (int p = 2; p <= 15; p++) begin
        int thr;
        rate = r[0];
        thr = r ? DH : DL;
        do_reset();
        toggle_run(p, 1, WH + 100);
        for (int c = 0; c < NCH; c++)
          chk($sformatf("R4 R6 R1 sweep rate%0d ch%0d spacing%0d", r, c, p + c),
              32'(los[c]), 32'((p + c) > thr + 1));
        chk("R9 muted where lost", 32'(dout & los), 32'h0);
      end
    end

    // R4: clear only after full window
    rate = 1'b1;
    do_reset();
    toggle_run(2, 0, WH - 10);
    chk("R4 before window end", 32'(los), 32'hF);
    toggle_run(2, 0, 20);
    chk("R4 after window end", 32'(los), 32'h0);

    // R5: a long gap restarts the window
    do_reset();
    toggle_run(2, 0, WH - 8);
    cyc(DH + 6);
    toggle_run(2, 0, WH - 8);
    chk("R5 window restarted", 32'(los), 32'hF);
    toggle_run(2, 0, 20);
    chk("R5 cleared after full window", 32'(los), 32'h0);

    // R3: exact declare edge, fast rate
    rx = ~rx;
    cyc(DH + 3);
    chk("R3 fast not yet declared", 32'(los), 32'h0);
    cyc(1);
    chk("R3 fast declared", 32'(los), 32'hF);
    chk("R9 output muted on declare", 32'(dout), 32'h0);

    // R3 R6: exact declare edge, slow rate
    rate = 1'b0;
    do_reset();
    toggle_run(2, 0, WL + 20);
    chk("R6 slow cleared", 32'(los), 32'h0);
    rx = ~rx;
    cyc(DL + 3);
    chk("R3 slow not yet declared", 32'(los), 32'h0);
    cyc(1);
    chk("R3 slow declared", 32'(los), 32'hF);

    // R8 R7: external condition ORs over cleared digital
    rate = 1'b1;
    do_reset();
    toggle_run(2, 0, WH + 20);
    chk("R8 both inactive", 32'(los), 32'h0);
    sd = 4'b1011;
    #1;
    chk("R8 R1 ext on ch2 only", 32'(los), 32'h4);
    sd = 4'hF;
    cyc(1);

    // R10 R2: digital declared but disabled -> pass-through with 2-cycle latency
    do_reset();
    off = 1'b1;
    #1;
    chk("R10 disabled hides status", 32'(los), 32'h0);
    cyc(1);
    rx = 4'b1010;
    cyc(1);
    chk("R2 one edge later old value", 32'(dout), 32'h0);
    cyc(1);
    chk("R2 two edges later new value", 32'(dout), 32'hA);
    rx = 4'hF;
    cyc(3);

    // R7 R9 R1: exhaustive detect x polarity with digital disabled
    for (int v = 0; v < 256; v++) begin
      {pol, sd} = v[7:0];
      #1;
      chk($sformatf("R7 ext sweep pol=%0h det=%0h", pol, sd), 32'(los), 32'(sd ^ pol));
      chk("R9 ext mute", 32'(dout), 32'(~(sd ^ pol) & 4'hF));
      @(negedge clk);
    end
    sd = '1;
    pol = '1;
    cyc(1);

    // R10: re-enabling exposes the declared digital state at once
    off = 1'b0;
    #1;
    chk("R10 re-enabled status", 32'(los), 32'hF);
    chk("R10 re-enabled mute", 32'(dout), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule